// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector memory command into a stream of per-element byte addresses for a load/store unit. A command is latched on a `start` pulse. It carries a mode, a base scalar, a second scalar (the stride, or the multiplier in create-index mode) and an element count. The block then walks elements 0, 1, 2 and so on. It offers one element address per cycle on a valid/ready stream, and each address is tagged with its element number. Loads and stores use the same patterns, so the block does not know which one the consumer is doing.

Four modes share one element sequencer:
- Contiguous mode steps through 8-byte elements.
- Strided mode adds a signed stride for each element.
- Indexed mode adds to the base a per-element byte offset, read through a combinational read port on another vector register.
- Create-index mode emits no addresses. It writes the value element-number times the scalar into a destination vector register through a write port, one element per cycle.

Back-pressure rules for the address stream: an offered address stays on the bus, with its element tag unchanged, until the consumer takes it with valid and ready both high at a clock edge. A new address can be offered in the cycle after a transfer, so the stream sustains one address per cycle while ready stays high. The index read port is sampled at the moment an element is issued. After that, the index source may change without affecting any address already offered.

Top module: `vec_addr_gen`

## Requirements
- R1: After reset, `addr_valid`, `wr_en`, `done` and `busy` are all low.
- R2: Mode code 0 (contiguous): element i has address base + 8*i.
- R3: Mode code 1 (strided): element i has address base + i*stride. The stride is signed two's complement, and the address wraps modulo 2^64.
- R4: Mode code 2 (indexed): element i has address base + off[i], modulo 2^64. Here off[i] is the 64-bit value returned on `idx_rd_data` while `idx_rd_addr` equals i.
- R5: Mode code 3 (create-index): the block writes element i with `wr_data` = i*stride (mod 2^64) and `wr_elem` = i. There is one write per cycle, on consecutive cycles, in increasing i. `addr_valid` stays low for the whole command.
- R6: An address-mode command with length n transfers exactly n addresses, tagged 0 to n-1 in increasing order. A length above VLEN_MAX is treated as VLEN_MAX.
- R7: While `addr_valid` is high and `addr_ready` is low, the next cycle still has `addr_valid` high, with `addr` and `addr_elem` unchanged.
- R8: `done` is high for exactly one cycle. That cycle is the one right after the last address transfer (or the last write in create-index mode). A zero-length command raises `done` without emitting anything.
- R9: A `start` pulse that arrives while `busy` is high is ignored.
- R10: `busy` is high from the cycle after an accepted `start` up to, but not including, the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, taken when not busy |
| mode | input | 2 | 0 contiguous, 1 strided, 2 indexed, 3 create-index |
| base | input | ADDR_W | Base byte address |
| stride | input | ADDR_W | Signed stride, or the create-index multiplier |
| vlen | input | LEN_W | Number of elements |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| idx_rd_addr | output | IDX_W | Element number read from the offset vector |
| idx_rd_data | input | ADDR_W | Offset for that element, combinational |
| addr_valid | output | 1 | Address offered |
| addr_ready | input | 1 | Consumer takes the address |
| addr | output | ADDR_W | Element byte address |
| addr_elem | output | IDX_W | Element number of `addr` |
| wr_en | output | 1 | Create-index write strobe |
| wr_elem | output | IDX_W | Destination element number |
| wr_data | output | ADDR_W | Value written |

## Verification
The bound checker checks these properties on every cycle:
- a stalled address holds steady;
- element tags step by one between back-to-back transfers;
- `done` lasts one cycle and only ends a busy period;
- no address appears while a create-index write is active.

Only the bench scenarios can show that the address values are right. Its scoreboard computes each expected address or written value from base, stride and offset. The scenarios cover:
- a negative stride that wraps below zero;
- a base near the top of the address space;
- the zero and maximum lengths;
- the exact cycle of `done`;
- a `start` pulse dropped while a command is running.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic [1:0] {
    MODE_CONTIG = 2'd0,
    MODE_STRIDE = 2'd1,
    MODE_INDEX  = 2'd2,
    MODE_CREATE = 2'd3
  } vag_mode_e;
endpackage

// File: rtl/vag_ctrl.sv
// Element sequencer: owns the command state, the element counter and done.
module vag_ctrl
  import vag_pkg::*;
#(
  parameter int VLEN_MAX = 64,
  localparam int LEN_W = $clog2(VLEN_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  vag_mode_e        cfg_mode,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             out_valid,
  input  logic             out_ready,
  output logic             accept,
  output logic             issue,
  output logic             busy,
  output logic             done,
  output logic [LEN_W-1:0] cnt,
  output vag_mode_e        mode_q
);
  localparam logic [LEN_W-1:0] LenMax = LEN_W'(VLEN_MAX);

  logic             run_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic             done_q;
  logic             all_issued;
  logic             slot_free;
  logic             finish;

  assign slot_free  = !out_valid || out_ready;
  assign all_issued = (cnt_q == len_q);
  assign accept     = start && !run_q;
  assign issue      = run_q && !all_issued && ((mode_q == MODE_CREATE) || slot_free);
  assign finish     = run_q && all_issued && ((mode_q == MODE_CREATE) || slot_free);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
      mode_q <= MODE_CONTIG;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (accept) begin
        run_q  <= 1'b1;
        cnt_q  <= '0;
        len_q  <= (cfg_len > LenMax) ? LenMax : cfg_len;
        mode_q <= cfg_mode;
      end else begin
        if (finish) run_q <= 1'b0;
        if (issue)  cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy = run_q;
  assign done = done_q;
  assign cnt  = cnt_q;
endmodule

// File: rtl/vag_accum.sv
// Running sum: init on load, add step on each advance (wraps at W bits).
module vag_accum #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] init,
  input  logic [W-1:0] step_in,
  input  logic         adv,
  output logic [W-1:0] acc
);
  logic [W-1:0] acc_q;
  logic [W-1:0] step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      step_q <= '0;
    end else if (load) begin
      acc_q  <= init;
      step_q <= step_in;
    end else if (adv) begin
      acc_q  <= acc_q + step_q;
    end
  end

  assign acc = acc_q;
endmodule

// File: rtl/vag_out_slice.sv
// Output holding register for a valid/ready stream with a tag.
module vag_out_slice #(
  parameter int W     = 64,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [W-1:0]     data_in,
  input  logic [TAG_W-1:0] tag_in,
  input  logic             ready,
  output logic             valid,
  output logic [W-1:0]     data,
  output logic [TAG_W-1:0] tag
);
  logic             valid_q;
  logic [W-1:0]     data_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      tag_q   <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      data_q  <= data_in;
      tag_q   <= tag_in;
    end else if (ready) begin
      valid_q <= 1'b0;
    end
  end

  assign valid = valid_q;
  assign data  = data_q;
  assign tag   = tag_q;
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
  import vag_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int VLEN_MAX   = 64,
  parameter int ELEM_BYTES = 8,
  localparam int LEN_W = $clog2(VLEN_MAX + 1),
  localparam int IDX_W = (VLEN_MAX > 1) ? $clog2(VLEN_MAX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic [LEN_W-1:0]  vlen,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  idx_rd_addr,
  input  logic [ADDR_W-1:0] idx_rd_data,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  addr_elem,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_elem,
  output logic [ADDR_W-1:0] wr_data
);
  localparam logic [ADDR_W-1:0] ElemStep = ADDR_W'(ELEM_BYTES);

  vag_mode_e          cfg_mode;
  vag_mode_e          mode_q;
  logic               accept;
  logic               issue;
  logic [LEN_W-1:0]   cnt;
  logic [ADDR_W-1:0]  acc;
  logic [ADDR_W-1:0]  acc_init;
  logic [ADDR_W-1:0]  acc_step;
  logic [ADDR_W-1:0]  base_q;
  logic [ADDR_W-1:0]  next_addr;
  logic [IDX_W-1:0]   elem_now;
  logic               is_create;
  logic               addr_load;
  logic               wr_en_q;
  logic [IDX_W-1:0]   wr_elem_q;
  logic [ADDR_W-1:0]  wr_data_q;

  assign cfg_mode = vag_mode_e'(mode);
  assign elem_now = cnt[IDX_W-1:0];
  assign is_create = (mode_q == MODE_CREATE);

  vag_ctrl #(.VLEN_MAX(VLEN_MAX)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cfg_mode (cfg_mode),
    .cfg_len  (vlen),
    .out_valid(addr_valid),
    .out_ready(addr_ready),
    .accept   (accept),
    .issue    (issue),
    .busy     (busy),
    .done     (done),
    .cnt      (cnt),
    .mode_q   (mode_q)
  );

  // Starting value and step per mode
  always_comb begin
    unique case (cfg_mode)
      MODE_CONTIG: begin acc_init = base; acc_step = ElemStep; end
      MODE_STRIDE: begin acc_init = base; acc_step = stride;   end
      MODE_CREATE: begin acc_init = '0;   acc_step = stride;   end
      default:     begin acc_init = base; acc_step = '0;       end
    endcase
  end

  vag_accum #(.W(ADDR_W)) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .init   (acc_init),
    .step_in(acc_step),
    .adv    (issue),
    .acc    (acc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      base_q <= '0;
    else if (accept) base_q <= base;
  end

  assign idx_rd_addr = elem_now;
  assign next_addr   = (mode_q == MODE_INDEX) ? (base_q + idx_rd_data) : acc;
  assign addr_load   = issue && !is_create;

  vag_out_slice #(.W(ADDR_W), .TAG_W(IDX_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (addr_load),
    .data_in(next_addr),
    .tag_in (elem_now),
    .ready  (addr_ready),
    .valid  (addr_valid),
    .data   (addr),
    .tag    (addr_elem)
  );

  // Create-index write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q   <= 1'b0;
      wr_elem_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= issue && is_create;
      if (issue && is_create) begin
        wr_elem_q <= elem_now;
        wr_data_q <= acc;
      end
    end
  end

  assign wr_en   = wr_en_q;
  assign wr_elem = wr_elem_q;
  assign wr_data = wr_data_q;
endmodule

// File: rtl/vag_checker.sv
module vag_checker #(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic [ADDR_W-1:0] addr,
  input logic [IDX_W-1:0]  addr_elem,
  input logic              wr_en
);
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr) && $stable(addr_elem)));

  // R6
  elem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_ready) |=> (!addr_valid || (addr_elem == IDX_W'($past(addr_elem) + 1'b1))));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && !busy));

  // R5
  create_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !addr_valid);
endmodule

bind vec_addr_gen vag_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .addr_valid(addr_valid),
  .addr_ready(addr_ready),
  .addr      (addr),
  .addr_elem (addr_elem),
  .wr_en     (wr_en)
);

// File: tb/vec_addr_gen_test.sv
module vec_addr_gen_test;
  localparam int AW = 64;
  localparam int VMAX = 64;
  localparam int LW = $clog2(VMAX + 1);
  localparam int IW = $clog2(VMAX);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [AW-1:0] base = '0;
  logic [AW-1:0] stride = '0;
  logic [LW-1:0] vlen = '0;
  logic          busy, done;
  logic [IW-1:0] idx_rd_addr;
  logic [AW-1:0] idx_rd_data;
  logic          addr_valid;
  logic          addr_ready = 1'b1;
  logic [AW-1:0] addr;
  logic [IW-1:0] addr_elem;
  logic          wr_en;
  logic [IW-1:0] wr_elem;
  logic [AW-1:0] wr_data;

  logic [AW-1:0] idx_mem [VMAX];
  assign idx_rd_data = idx_mem[idx_rd_addr];

  always #10 clk = ~clk;

  vec_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base(base),
    .stride(stride), .vlen(vlen), .busy(busy), .done(done),
    .idx_rd_addr(idx_rd_addr), .idx_rd_data(idx_rd_data),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr(addr),
    .addr_elem(addr_elem), .wr_en(wr_en), .wr_elem(wr_elem), .wr_data(wr_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int cyc = 0;
  int last_xfer = -10;
  int done_seen = 0;
  bit expect_empty_done = 0;
  bit stall_en = 0;
  logic [AW+IW-1:0] exp_q [$];   // {value, element}

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // ready pattern, driven away from the sampling edge
  initial forever begin
    @(posedge clk); #2;
    addr_ready = stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  // monitor / scoreboard
  logic          prev_stall = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [IW-1:0] prev_elem = '0;
  always @(negedge clk) if (rst_n) begin
    if (prev_stall) begin
      chk(addr_valid && addr == prev_addr && addr_elem == prev_elem, "R7 hold", addr, prev_addr);
    end
    prev_stall = addr_valid && !addr_ready;
    prev_addr  = addr;
    prev_elem  = addr_elem;
    if (addr_valid && addr_ready) begin
      if (exp_q.size() == 0) chk(0, "R6 extra address", addr, '0);
      else begin
        logic [AW+IW-1:0] e;
        e = exp_q.pop_front();
        chk(addr == e[AW+IW-1:IW], "R2/R3/R4 address value", addr, e[AW+IW-1:IW]);
        chk(addr_elem == e[IW-1:0], "R6 element order", AW'(addr_elem), AW'(e[IW-1:0]));
      end
      last_xfer = cyc;
    end
    if (wr_en) begin
      chk(!addr_valid, "R5 no address in create mode", AW'(addr_valid), '0);
      if (exp_q.size() == 0) chk(0, "R5 extra write", wr_data, '0);
      else begin
        logic [AW+IW-1:0] e;
        e = exp_q.pop_front();
        chk(wr_data == e[AW+IW-1:IW], "R5 write value", wr_data, e[AW+IW-1:IW]);
        chk(wr_elem == e[IW-1:0], "R5 write element", AW'(wr_elem), AW'(e[IW-1:0]));
      end
      if (last_xfer != cyc - 1 && exp_q.size() < 63 && wr_elem != 0)
        chk(0, "R5 writes not consecutive", AW'(cyc), AW'(last_xfer + 1));
      last_xfer = cyc;
    end
    if (done) begin
      done_seen++;
      chk(!busy, "R10 busy low in done cycle", AW'(busy), '0);
      if (!expect_empty_done)
        chk(cyc == last_xfer + 1, "R8 done one cycle after last", AW'(cyc), AW'(last_xfer + 1));
    end
  end

  task automatic run_cmd(input logic [1:0] m, input logic [AW-1:0] b, input logic [AW-1:0] s,
                         input int len, input bit inject_start);
    int eff;
    int d0;
    eff = (len > VMAX) ? VMAX : len;
    for (int i = 0; i < eff; i++) begin
      logic [AW-1:0] v;
      unique case (m)
        2'd0: v = b + AW'(i) * 64'd8;
        2'd1: v = b + AW'(i) * s;
        2'd2: v = b + idx_mem[i];
        default: v = AW'(i) * s;
      endcase
      exp_q.push_back({v, IW'(i)});
    end
    expect_empty_done = (eff == 0);
    d0 = done_seen;
    @(posedge clk); #2;
    start = 1'b1; mode = m; base = b; stride = s; vlen = LW'(len);
    @(posedge clk); #2;
    start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R10 busy after start", AW'(busy), 64'd1);
    if (inject_start) begin
      @(posedge clk); #2;
      start = 1'b1; mode = 2'd0; base = 64'hDEAD_0000; vlen = LW'(3);
      @(posedge clk); #2;
      start = 1'b0;
    end
    begin
      int t;
      for (t = 0; t < 2000 && done_seen == d0; t++) @(negedge clk);
      if (done_seen == d0) chk(0, "R8 done never seen", '0, 64'd1);
    end
    @(negedge clk);
    chk(exp_q.size() == 0, "R6 count of elements", AW'(exp_q.size()), '0);
    chk(done_seen == d0 + 1 && !busy, "R9/R8 single completion", AW'(done_seen - d0), 64'd1);
    exp_q.delete();
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog expired", '0, '0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < VMAX; i++) idx_mem[i] = AW'(i * 40) ^ (AW'(i) << 33) - 64'd16;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk(!addr_valid, "R1 addr_valid reset", AW'(addr_valid), '0);
    chk(!wr_en, "R1 wr_en reset", AW'(wr_en), '0);
    chk(!done, "R1 done reset", AW'(done), '0);
    chk(!busy, "R1 busy reset", AW'(busy), '0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    stall_en = 0;
    run_cmd(2'd0, 64'h1000, '0, 8, 0);                           // R2
    stall_en = 1;
    run_cmd(2'd0, 64'h2000, '0, 20, 0);                          // R2 with stalls
    run_cmd(2'd1, 64'h40, -64'sd24, 12, 0);                      // R3 negative, wraps
    run_cmd(2'd1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h10, 5, 0);        // R3 top wrap
    run_cmd(2'd2, 64'h8000, '0, 16, 0);                          // R4
    stall_en = 0;
    run_cmd(2'd2, 64'hFFFF_FFFF_0000_0000, '0, 7, 0);            // R4 no stall
    run_cmd(2'd3, '0, 64'd3, 10, 0);                             // R5
    run_cmd(2'd3, 64'h1234, -64'sd5, 4, 0);                      // R5 negative scalar
    run_cmd(2'd0, 64'h500, '0, 0, 0);                            // R8 zero length
    stall_en = 1;
    run_cmd(2'd0, 64'h9000, '0, 64, 0);                          // R6 max length
    run_cmd(2'd1, 64'h100, 64'd72, 6, 1);                        // R9 start ignored while busy
    stall_en = 0;
    run_cmd(2'd0, 64'h3000, '0, 64, 0);                          // R6 back-to-back rate
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule